// File: doc/BRIEF.md
# Gated Differential Clock Fan-out Controller

This block distributes one source clock to a parameterised number of output lanes (eight by default). Each lane produces a true/complement clock pair and a drive-enable flag. A flag of 0 means the pair is tristated. An optional divide-by-2 stage sits in front of all lanes. Each lane then applies its own combination of enable, stop and power-down conditions.

The block runs on a core clock `clk`. The source clock arrives as a level `src_lvl`, sampled once per core cycle. The power-down, stop and output-enable pins can be inverted as a group by a polarity pin before use. Per-lane configuration words choose:

- which lanes are enabled;
- which lanes respond to the stop pin;
- whether a stopped lane is held driven (true high, complement low) or tristated.

Stop and power-down requests pass through a synchroniser. A lane changes between running and stopped only while its output clock is low, so no shortened pulse ever appears. A latched lock output records the first PLL lock indication and clears on power-down or reset.

Top module: `clkctl_out_ctrl`

## Requirements
- R1: The output clock runs at half the source rate when `src_div_n` is 0 or `cfg_mode[0]` is 0; otherwise it follows the source at 1x. In the 1x case a source that toggles every core cycle gives 8 output transitions per 8 cycles; in the halved case it gives 4.
- R2: When `pol_inv` is 1, the `oe_pin`, `stop_n_pin` and `pwrdn_n_pin` inputs are inverted before use. When it is 0, they are used unchanged. `src_div_n` is never inverted.
- R3: A lane whose effective OE pin is 0, or whose `cfg_oe` bit is 0, is disabled. A disabled lane shows `drv_en`=0 with `clk_p`=`clk_n`=0, and this overrides every other condition.
- R4: An effective `stop_n_pin` of 0 stops only the enabled lanes whose `cfg_stop_en` bit is 1. Lanes with a 0 bit keep running.
- R5: An effective `pwrdn_n_pin` of 0 stops every enabled lane. Power-down takes priority over stop.
- R6: A lane stopped by power-down uses `cfg_mode[7]` to pick its stopped state, and a lane stopped by stop uses `cfg_mode[6]`. The value 0 means driven (`clk_p`=1, `clk_n`=0, `drv_en`=1); the value 1 means tristated (all three 0).
- R7: `lock_out` rises the cycle after `pll_lock` is seen high. It stays high after `pll_lock` falls, and clears only during effective power-down or reset.
- R8: A lane changes between running and stopped only at an edge where its output clock was low. A stopped lane that is tristated or held driven therefore never shows a high pulse shorter than a source phase.
- R9: A running lane drives `drv_en`=1 with `clk_n` the complement of `clk_p`. Once power-down or stop is released, the lane is running again within 12 core cycles.
- R10: During reset every lane is tristated and `lock_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 1 | Source clock level, sampled by clk |
| src_div_n | input | 1 | Divide-by-2 select, active low |
| stop_n_pin | input | 1 | Stop request, active low before polarity |
| pwrdn_n_pin | input | 1 | Power-down request, active low before polarity |
| oe_pin | input | 8 | Per-lane output-enable pins, active high before polarity |
| pol_inv | input | 1 | Inverts OE, stop and power-down pins when 1 |
| cfg_mode | input | 8 | Bit0 1x select, bit6 stop-state, bit7 power-down-state |
| cfg_oe | input | 8 | Per-lane enable bits |
| cfg_stop_en | input | 8 | Per-lane stop-participation bits |
| pll_lock | input | 1 | PLL lock indication |
| clk_p | output | 8 | True output clocks |
| clk_n | output | 8 | Complement output clocks |
| drv_en | output | 8 | Per-lane drive enable (0 = tristate) |
| lock_out | output | 1 | Latched lock indication |

## Verification
The hardest behaviour to observe is the priority among the three gating causes. A lane can be disabled, powered down and stop-gated all at once, each cause choosing a different output state. The pin polarity and the divide selection change the meaning of the same pin levels.

Random rounds draw every pin, the polarity pin and all three configuration words together, so overlapping causes occur often. Each round holds its inputs long enough for the synchroniser and the low-phase gate to settle. The bench then classifies all lanes against its own priority model, and counts output-clock transitions to confirm the rate.

Directed rounds add mixed stop-participation masks, both stopped-state choices, and the lock latch across power-down.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   // Request carried through the synchroniser into each lane
   typedef struct packed {
      logic halt;   // lane should be stopped
      logic hiz;    // stopped state is tristate
   } lane_req_t;

   localparam int REQ_W = $bits(lane_req_t);
endpackage

// File: rtl/clkctl_pin_pol.sv
module clkctl_pin_pol #(
   parameter int N_OUT   = 8,
   parameter bit HAS_INV = 1'b1
) (
   input  logic             pol_inv,
   input  logic [N_OUT-1:0] oe_raw,
   input  logic             stop_n_raw,
   input  logic             pwrdn_n_raw,
   output logic [N_OUT-1:0] oe_eff,
   output logic             stop_act,
   output logic             pwrdn_act
);
   initial begin
      if (N_OUT < 1) $error("clkctl_pin_pol: N_OUT must be at least 1");
   end

   logic             flip;
   logic [N_OUT-1:0] oe_lvl;
   logic             stop_lvl;
   logic             pwrdn_lvl;

   generate
      if (HAS_INV) begin : g_inv
         assign flip = pol_inv;
      end else begin : g_noinv
         logic unused_pol;
         assign unused_pol = pol_inv;
         assign flip = 1'b0;
      end
   endgenerate

   always_comb begin
      oe_lvl    = oe_raw ^ {N_OUT{flip}};
      stop_lvl  = stop_n_raw ^ flip;
      pwrdn_lvl = pwrdn_n_raw ^ flip;
      oe_eff    = oe_lvl;
      stop_act  = ~stop_lvl;
      pwrdn_act = ~pwrdn_lvl;
   end
endmodule

// File: rtl/clkctl_src_div.sv
module clkctl_src_div (
   input  logic clk,
   input  logic rst_n,
   input  logic src_lvl,
   input  logic half_sel,
   output logic base_clk
);
   logic src_q;
   logic div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         div_q <= 1'b0;
      end else begin
         src_q <= src_lvl;
         if (src_lvl && !src_q) div_q <= ~div_q;
      end
   end

   assign base_clk = half_sel ? div_q : src_q;

   // R1: the halved clock only moves at a rising source sample
   p_div_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q != $past(div_q)) |-> (src_q && !$past(src_q)));
endmodule

// File: rtl/clkctl_lane.sv
module clkctl_lane
   import clkctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_clk,
   input  logic disabled,
   input  logic pd_act,
   input  logic stop_act,
   input  logic stop_en,
   input  logic pd_hiz,
   input  logic stop_hiz,
   output logic out_p,
   output logic out_n,
   output logic out_drv
);
   initial begin
      if (SYNC_STAGES < 2) $error("clkctl_lane: SYNC_STAGES must be at least 2");
   end

   lane_req_t req_c;
   lane_req_t sync_q [SYNC_STAGES];
   lane_req_t req_s;
   logic      run_q;
   logic      hiz_q;

   // Priority: disable, then power-down, then stop
   always_comb begin
      req_c.halt = disabled | pd_act | (stop_act & stop_en);
      if (disabled)    req_c.hiz = 1'b1;
      else if (pd_act) req_c.hiz = pd_hiz;
      else             req_c.hiz = stop_hiz;
   end

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '{halt: 1'b1, hiz: 1'b1};
            else if (s == 0) sync_q[s] <= req_c;
            else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign req_s = sync_q[SYNC_STAGES-1];

   // State only moves while the output clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         hiz_q <= 1'b1;
      end else if (!base_clk) begin
         run_q <= ~req_s.halt;
         hiz_q <= req_s.hiz;
      end
   end

   always_comb begin
      if (run_q) begin
         out_p   = base_clk;
         out_n   = ~base_clk;
         out_drv = 1'b1;
      end else if (hiz_q) begin
         out_p   = 1'b0;
         out_n   = 1'b0;
         out_drv = 1'b0;
      end else begin
         out_p   = 1'b1;
         out_n   = 1'b0;
         out_drv = 1'b1;
      end
   end

   // R8: a lane starts or stops only after a low output phase
   p_no_runt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != $past(run_q)) |-> !$past(base_clk));

   // R9: a running lane drives a complementary pair
   p_run_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (out_drv && (out_n == ~out_p)));

   // R6: a driven stopped lane holds true high, complement low
   p_hold_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !hiz_q) |-> (out_p && !out_n && out_drv));
endmodule

// File: rtl/clkctl_lock.sv
module clkctl_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic pll_lock,
   input  logic pd_act,
   output logic lock_out
);
   logic lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lock_q <= 1'b0;
      else if (pd_act)   lock_q <= 1'b0;
      else if (pll_lock) lock_q <= 1'b1;
   end

   assign lock_out = lock_q;

   // R7: once latched, lock holds while not powered down
   p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !pd_act) |=> lock_q);
endmodule

// File: rtl/clkctl_out_ctrl.sv
module clkctl_out_ctrl #(
   parameter int N_OUT       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_INV     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_lvl,
   input  logic             src_div_n,
   input  logic             stop_n_pin,
   input  logic             pwrdn_n_pin,
   input  logic [N_OUT-1:0] oe_pin,
   input  logic             pol_inv,
   input  logic [7:0]       cfg_mode,
   input  logic [N_OUT-1:0] cfg_oe,
   input  logic [N_OUT-1:0] cfg_stop_en,
   input  logic             pll_lock,
   output logic [N_OUT-1:0] clk_p,
   output logic [N_OUT-1:0] clk_n,
   output logic [N_OUT-1:0] drv_en,
   output logic             lock_out
);
   localparam int MODE_X1   = 0;
   localparam int MODE_STOP = 6;
   localparam int MODE_PD   = 7;

   initial begin
      if (N_OUT < 1 || N_OUT > 64) $error("clkctl_out_ctrl: N_OUT out of range");
   end

   logic [N_OUT-1:0] oe_eff;
   logic             stop_act;
   logic             pd_act;
   logic             half_sel;
   logic             base_clk;
   logic [5:0]       unused_mode;

   assign unused_mode = cfg_mode[5:0];
   assign half_sel    = ~src_div_n | ~cfg_mode[MODE_X1];

   clkctl_pin_pol #(.N_OUT(N_OUT), .HAS_INV(HAS_INV)) pol_i (
      .pol_inv    (pol_inv),
      .oe_raw     (oe_pin),
      .stop_n_raw (stop_n_pin),
      .pwrdn_n_raw(pwrdn_n_pin),
      .oe_eff     (oe_eff),
      .stop_act   (stop_act),
      .pwrdn_act  (pd_act)
   );

   clkctl_src_div div_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_lvl (src_lvl),
      .half_sel(half_sel),
      .base_clk(base_clk)
   );

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_lane
         clkctl_lane #(.SYNC_STAGES(SYNC_STAGES)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .base_clk(base_clk),
            .disabled(~(oe_eff[i] & cfg_oe[i])),
            .pd_act  (pd_act),
            .stop_act(stop_act),
            .stop_en (cfg_stop_en[i]),
            .pd_hiz  (cfg_mode[MODE_PD]),
            .stop_hiz(cfg_mode[MODE_STOP]),
            .out_p   (clk_p[i]),
            .out_n   (clk_n[i]),
            .out_drv (drv_en[i])
         );
      end
   endgenerate

   clkctl_lock lock_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pll_lock(pll_lock),
      .pd_act  (pd_act),
      .lock_out(lock_out)
   );

   // R3: a tristated lane never drives either leg
   p_tri_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en == '0) |-> ((clk_p == '0) && (clk_n == '0)));
endmodule

// File: tb/clkctl_out_ctrl_tb_top.sv
module clkctl_out_ctrl_tb_top;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_lvl = 1'b0;
   logic         src_div_n = 1'b1;
   logic         stop_n_pin = 1'b1;
   logic         pwrdn_n_pin = 1'b1;
   logic [N-1:0] oe_pin = '1;
   logic         pol_inv = 1'b0;
   logic [7:0]   cfg_mode = 8'h01;
   logic [N-1:0] cfg_oe = '1;
   logic [N-1:0] cfg_stop_en = '0;
   logic         pll_lock = 1'b0;
   logic [N-1:0] clk_p, clk_n, drv_en;
   logic         lock_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(negedge clk) src_lvl <= ~src_lvl;

   clkctl_out_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .src_div_n(src_div_n),
      .stop_n_pin(stop_n_pin), .pwrdn_n_pin(pwrdn_n_pin), .oe_pin(oe_pin),
      .pol_inv(pol_inv), .cfg_mode(cfg_mode), .cfg_oe(cfg_oe),
      .cfg_stop_en(cfg_stop_en), .pll_lock(pll_lock), .clk_p(clk_p),
      .clk_n(clk_n), .drv_en(drv_en), .lock_out(lock_out)
   );

   // 0 run, 1 driven stop, 2 tristate
   function automatic int exp_state(int i);
      logic flip, oe_e, stop_a, pd_a;
      flip   = pol_inv;
      oe_e   = oe_pin[i] ^ flip;
      stop_a = ~(stop_n_pin ^ flip);
      pd_a   = ~(pwrdn_n_pin ^ flip);
      if (!(oe_e && cfg_oe[i])) return 2;
      if (pd_a) return cfg_mode[7] ? 2 : 1;
      if (stop_a && cfg_stop_en[i]) return cfg_mode[6] ? 2 : 1;
      return 0;
   endfunction

   function automatic int exp_edges();
      return (!src_div_n || !cfg_mode[0]) ? 4 : 8;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Let settle, then watch 9 samples per lane
   task automatic settle_and_check(string tag);
      int st [N];
      int edges [N];
      bit pair_ok [N];
      bit hold_ok [N];
      logic [N-1:0] prev;
      repeat (16) @(posedge clk);
      #1;
      for (int i = 0; i < N; i++) begin
         st[i] = exp_state(i);
         edges[i] = 0;
         pair_ok[i] = 1'b1;
         hold_ok[i] = 1'b1;
      end
      prev = clk_p;
      for (int k = 0; k < 9; k++) begin
         if (k > 0) begin
            @(posedge clk);
            #1;
         end
         for (int i = 0; i < N; i++) begin
            if (k > 0 && clk_p[i] != prev[i]) edges[i]++;
            case (st[i])
               0: if (!drv_en[i] || clk_n[i] == clk_p[i]) pair_ok[i] = 1'b0;
               1: if (!(clk_p[i] && !clk_n[i] && drv_en[i])) hold_ok[i] = 1'b0;
               default: if (clk_p[i] || clk_n[i] || drv_en[i]) hold_ok[i] = 1'b0;
            endcase
         end
         prev = clk_p;
      end
      for (int i = 0; i < N; i++) begin
         if (st[i] == 0) begin
            check(pair_ok[i], "R9", {tag, " run pair"}, 0, 1);
            check(edges[i] == exp_edges(), "R1", {tag, " edge count"}, edges[i], exp_edges());
         end else if (st[i] == 1) begin
            check(hold_ok[i], "R6", {tag, " driven stop"}, int'(clk_p[i]), 1);
         end else begin
            check(hold_ok[i], "R3", {tag, " tristate"}, int'(drv_en[i]), 0);
         end
      end
   endtask

   task automatic apply(logic dv, logic st, logic pd, logic [N-1:0] oe, logic inv,
                        logic [7:0] md, logic [N-1:0] en, logic [N-1:0] se);
      @(negedge clk);
      src_div_n = dv; stop_n_pin = st; pwrdn_n_pin = pd; oe_pin = oe;
      pol_inv = inv; cfg_mode = md; cfg_oe = en; cfg_stop_en = se;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #1;
      check(drv_en == '0 && clk_p == '0 && clk_n == '0, "R10", "reset tristate",
            int'(drv_en), 0);
      check(lock_out == 1'b0, "R10", "reset lock", int'(lock_out), 0);
      @(negedge clk) rst_n = 1'b1;

      // R1 both rates
      apply(1, 1, 1, '1, 0, 8'h01, '1, '0); settle_and_check("x1");
      apply(0, 1, 1, '1, 0, 8'h01, '1, '0); settle_and_check("div pin");
      apply(1, 1, 1, '1, 0, 8'h00, '1, '0); settle_and_check("div reg");
      // R4 mixed stop mask, driven then tristate
      apply(1, 0, 1, '1, 0, 8'h01, 8'hA5, 8'h3C); settle_and_check("R4 stop drv");
      apply(1, 0, 1, '1, 0, 8'h41, '1, 8'hC3); settle_and_check("R4 stop tri");
      // R5 power-down all, both states
      apply(1, 1, 0, '1, 0, 8'h01, '1, '0); settle_and_check("R5 pd drv");
      apply(1, 0, 0, '1, 0, 8'h81, '1, 8'h0F); settle_and_check("R5 pd tri");
      // R9 release
      apply(1, 1, 1, '1, 0, 8'h01, '1, 8'h0F); settle_and_check("R9 release");
      // R2 inverted polarity: inverted stop, run lanes need oe low
      apply(1, 1, 0, 8'h0F, 1, 8'h01, '1, 8'h03); settle_and_check("R2 inv");
      // R3 disable by pin and by bit together with pd
      apply(1, 1, 0, 8'hF0, 0, 8'h01, 8'h3C, '0); settle_and_check("R3 dis");

      // R7 lock latch
      apply(1, 1, 1, '1, 0, 8'h01, '1, '0);
      @(negedge clk) pll_lock = 1'b1;
      @(negedge clk) pll_lock = 1'b0;
      repeat (5) @(negedge clk);
      check(lock_out == 1'b1, "R7", "lock held", int'(lock_out), 1);
      pwrdn_n_pin = 1'b0;
      @(negedge clk);
      check(lock_out == 1'b0, "R7", "lock cleared", int'(lock_out), 0);
      pwrdn_n_pin = 1'b1;
      repeat (3) @(negedge clk);
      check(lock_out == 1'b0, "R7", "lock stays clear", int'(lock_out), 0);

      // Random rounds
      for (int r = 0; r < 40; r++) begin
         apply(1'($urandom), 1'($urandom), 1'($urandom), N'($urandom), 1'($urandom),
               8'($urandom), N'($urandom), N'($urandom));
         settle_and_check("rand");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule